// File: doc/BRIEF.md
# Masked Address Breakpoint Comparator

This block watches every processor bus cycle. It raises a one-clock hit when the cycle's address equals a programmed compare value. Address bits that are set in a programmable mask are left out of that comparison. A control register arms the comparator and chooses what kind of cycle may hit. In program mode only instruction fetches can hit. In bus mode only data accesses can hit, and reads and writes count alike. A single-shot option disarms the comparator after its first hit. Without it, every matching cycle hits.

The two hit outputs are meant for an interrupt gate that raises the debug interrupt. Software sets up the compare, mask and control registers through a plain write/read port. The cycle type comes from the low two bits of the function code. Pattern `10` is a program fetch and pattern `01` is a data access. The top bit of the function code, the privilege level, plays no part.

Top module: `bkpt_cmp_top`

## Requirements
- R1: A cycle can hit only if `((cyc_addr ^ compare) & ~mask) == 0`. A mask bit of 1 removes that address bit from the comparison.
- R2: Program mode is control bits arm=1 and prog=1 with bus=0. In this mode `prog_hit` pulses only for cycles whose `cyc_fc[1:0]` is `2'b10`, at either privilege level.
- R3: Bus mode is control bits arm=1 and bus=1 with prog=0. In this mode `bus_hit` pulses only for cycles whose `cyc_fc[1:0]` is `2'b01`, whatever the transfer direction.
- R4: When prog and bus are both set, or both clear, neither hit output is asserted.
- R5: With the single bit set, the arm bit clears itself on the clock edge that registers a hit, so later matching cycles do not hit until software sets arm again.
- R6: With the single bit clear, every matching cycle gives a hit pulse exactly one clock wide, on the clock after the cycle is sampled. Back-to-back matches give back-to-back pulses.
- R7: While the arm bit is clear, `prog_hit` and `bus_hit` stay low whatever the bus activity.
- R8: Register offsets are 0 for compare, 1 for mask and 2 for control. Control bits are arm [0], prog [1], bus [2] and single [3]. Offset 3 reads as zero. Writes take effect on the next edge, and reads are combinational. Reset clears all three registers to zero.
- R9: A control write on the same edge as a single-shot hit takes priority over the self-clear. The hit of that cycle is still reported.
- R10: A cycle with `cyc_valid` low never produces a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cyc_valid | input | 1 | Bus cycle present this clock |
| cyc_addr | input | 32 | Bus cycle address |
| cyc_fc | input | 3 | Bus cycle function code |
| prog_hit | output | 1 | Program breakpoint hit pulse |
| bus_hit | output | 1 | Bus breakpoint hit pulse |

## Verification
The assertions assume that the bus presents at most one cycle per clock. They also assume that `cyc_addr` and `cyc_fc` are held stable around the sampling edge whenever `cyc_valid` is high. The bench changes every input only on the falling clock edge and moves to the next cycle only after a full period, so this assumption holds throughout. Register writes go through the same falling-edge driver. Register writes overlap a bus cycle only in the one case that R9 describes.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int CTRL_W = 4;

    // Register offsets; control bit layout is read back by software
    localparam logic [1:0] OFF_CMP  = 2'd0;
    localparam logic [1:0] OFF_MASK = 2'd1;
    localparam logic [1:0] OFF_CTRL = 2'd2;

    // Function-code low-bit patterns that classify a cycle
    localparam logic [1:0] FC_PROG = 2'b10;
    localparam logic [1:0] FC_DATA = 2'b01;

    typedef struct packed {
        logic single;   // bit 3
        logic bus_en;   // bit 2
        logic prog_en;  // bit 1
        logic arm;      // bit 0
    } ctrl_t;

    typedef struct packed {
        logic prog;
        logic bus;
    } hit_t;
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              hit_any,
    output logic [ADDR_W-1:0] cmp_o,
    output logic [ADDR_W-1:0] mask_o,
    output ctrl_t             ctrl_o,
    output logic [ADDR_W-1:0] rdata
);
    typedef struct packed {
        logic [ADDR_W-1:0] cmp;
        logic [ADDR_W-1:0] mask;
        ctrl_t             ctrl;
    } state_t;

    state_t s_d, s_q;
    logic   ctrl_wr;

    assign ctrl_wr = we && (addr == OFF_CTRL);

    always_comb begin
        s_d = s_q;
        // single-shot self-disarm; a software write below overrides it
        if (hit_any && s_q.ctrl.single) begin
            s_d.ctrl.arm = 1'b0;
        end
        if (we) begin
            case (addr)
                OFF_CMP:  s_d.cmp  = wdata;
                OFF_MASK: s_d.mask = wdata;
                OFF_CTRL: s_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_CMP:  rdata = s_q.cmp;
            OFF_MASK: rdata = s_q.mask;
            OFF_CTRL: rdata[CTRL_W-1:0] = s_q.ctrl;
            default:  rdata = '0;
        endcase
    end

    assign cmp_o  = s_q.cmp;
    assign mask_o = s_q.mask;
    assign ctrl_o = s_q.ctrl;

    AST_SINGLE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_any && s_q.ctrl.single && !ctrl_wr) |=> !s_q.ctrl.arm); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (s_q.ctrl == $past(wdata[CTRL_W-1:0]))); // R9
endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [1:0]        fc_lo,
    input  logic [ADDR_W-1:0] cmp,
    input  logic [ADDR_W-1:0] mask,
    input  ctrl_t             ctrl,
    output logic              prog_match,
    output logic              bus_match
);
    logic [ADDR_W-1:0] bit_diff;
    logic              addr_eq;
    logic              prog_mode;
    logic              bus_mode;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_diff[i] = (cyc_addr[i] ^ cmp[i]) & ~mask[i];
    end

    assign addr_eq   = ~|bit_diff;
    assign prog_mode = ctrl.arm && ctrl.prog_en && !ctrl.bus_en;
    assign bus_mode  = ctrl.arm && ctrl.bus_en && !ctrl.prog_en;

    assign prog_match = cyc_valid && addr_eq && prog_mode && (fc_lo == FC_PROG);
    assign bus_match  = cyc_valid && addr_eq && bus_mode  && (fc_lo == FC_DATA);
endmodule

// File: rtl/bkpt_cmp_top.sv
module bkpt_cmp_top
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int FC_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [FC_W-1:0]   cyc_fc,
    output logic              prog_hit,
    output logic              bus_hit
);
    logic [ADDR_W-1:0] cmp_w, mask_w;
    ctrl_t             ctrl_w;
    logic              pm, bm;
    hit_t              hit_d, hit_q;
    logic              unused_fc_hi;

    assign unused_fc_hi = ^cyc_fc[FC_W-1:2];

    bkpt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .hit_any (pm | bm),
        .cmp_o   (cmp_w),
        .mask_o  (mask_w),
        .ctrl_o  (ctrl_w),
        .rdata   (reg_rdata)
    );

    bkpt_match #(.ADDR_W(ADDR_W)) u_match (
        .cyc_valid  (cyc_valid),
        .cyc_addr   (cyc_addr),
        .fc_lo      (cyc_fc[1:0]),
        .cmp        (cmp_w),
        .mask       (mask_w),
        .ctrl       (ctrl_w),
        .prog_match (pm),
        .bus_match  (bm)
    );

    always_comb begin
        hit_d      = '0;
        hit_d.prog = pm;
        hit_d.bus  = bm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= '0;
        end else begin
            hit_q <= hit_d;
        end
    end

    assign prog_hit = hit_q.prog;
    assign bus_hit  = hit_q.bus;

    AST_PROG_FETCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_hit |-> $past(cyc_valid && cyc_fc[1:0] == FC_PROG)); // R2
    AST_BUS_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hit |-> $past(cyc_valid && cyc_fc[1:0] == FC_DATA)); // R3
    AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_hit || bus_hit) |-> $past(ctrl_w.prog_en != ctrl_w.bus_en)); // R4
    AST_ARMED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_hit || bus_hit) |-> $past(ctrl_w.arm)); // R7
    AST_VALID_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_hit || bus_hit) |-> $past(cyc_valid)); // R10
    AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_hit || bus_hit) |-> $past(((cyc_addr ^ cmp_w) & ~mask_w) == '0)); // R1
    AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_hit, bus_hit})); // R4
endmodule

// File: tb/sim_bkpt_cmp_top.sv
`timescale 1ns/1ps
module sim_bkpt_cmp_top;
    localparam int AW = 32;
    localparam logic [3:0] ARM = 4'h1, PROG = 4'h2, BUS = 4'h4, SGL = 4'h8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          cyc_valid = 1'b0;
    logic [AW-1:0] cyc_addr = '0;
    logic [2:0]    cyc_fc = '0;
    logic          prog_hit, bus_hit;

    int checks = 0;
    int failures = 0;
    int cnt = 0;
    bit done = 0;

    typedef struct {
        int    due;
        logic  ep;
        logic  eb;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 1;

    bkpt_cmp_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_valid(cyc_valid),
        .cyc_addr(cyc_addr), .cyc_fc(cyc_fc), .prog_hit(prog_hit), .bus_hit(bus_hit)
    );

    // Monitor: pops items whose result is due and compares at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cnt) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (prog_hit !== e.ep || bus_hit !== e.eb) begin
                failures++;
                $display("FAIL %s: hits prog=%b bus=%b expected prog=%b bus=%b",
                         e.tag, prog_hit, bus_hit, e.ep, e.eb);
            end
        end
    end

    // Driver: one clock of stimulus plus its expected hit outputs
    task automatic op(input logic we, input logic [1:0] ra, input logic [AW-1:0] wd,
                      input logic v, input logic [AW-1:0] a, input logic [2:0] fc,
                      input logic ep, input logic eb, input string tag);
        exp_t e;
        @(negedge clk);
        reg_we = we; reg_addr = ra; reg_wdata = wd;
        cyc_valid = v; cyc_addr = a; cyc_fc = fc;
        e.due = cnt + 1; e.ep = ep; e.eb = eb; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(input logic [1:0] ra, input logic [AW-1:0] wd);
        op(1'b1, ra, wd, 1'b0, '0, 3'b000, 1'b0, 1'b0, "R8");
    endtask

    task automatic cyc(input logic v, input logic [AW-1:0] a, input logic [2:0] fc,
                       input logic ep, input logic eb, input string tag);
        op(1'b0, 2'd0, '0, v, a, fc, ep, eb, tag);
    endtask

    task automatic rd_chk(input logic [1:0] ra, input logic [AW-1:0] exp, input string tag);
        cyc(1'b0, '0, 3'b000, 1'b0, 1'b0, tag);
        reg_addr = ra;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            failures++;
            $display("FAIL %s: reg %0d read %h expected %h", tag, ra, reg_rdata, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run incomplete, expected to end");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset values
        rd_chk(2'd0, '0, "R8");
        rd_chk(2'd1, '0, "R8");
        rd_chk(2'd2, '0, "R8");

        // R7: not armed, no hit
        wr(2'd0, 32'h0000_4000);
        wr(2'd2, {28'd0, PROG});
        cyc(1'b1, 32'h0000_4000, 3'b110, 1'b0, 1'b0, "R7");

        // R2 / R6 / R10 / R1: program mode, multiple shot
        wr(2'd2, {28'd0, ARM | PROG});
        rd_chk(2'd2, {28'd0, ARM | PROG}, "R8");
        rd_chk(2'd3, '0, "R8");
        cyc(1'b1, 32'h0000_4000, 3'b110, 1'b1, 1'b0, "R2");
        cyc(1'b1, 32'h0000_4000, 3'b110, 1'b1, 1'b0, "R6");
        cyc(1'b0, 32'h0000_4000, 3'b110, 1'b0, 1'b0, "R10");
        cyc(1'b1, 32'h0000_4000, 3'b101, 1'b0, 1'b0, "R2");
        cyc(1'b1, 32'h0000_4000, 3'b010, 1'b1, 1'b0, "R2");
        cyc(1'b1, 32'h0000_4004, 3'b110, 1'b0, 1'b0, "R1");

        // R1: masked compare
        wr(2'd1, 32'h0000_00FF);
        rd_chk(2'd1, 32'h0000_00FF, "R8");
        cyc(1'b1, 32'h0000_40AB, 3'b110, 1'b1, 1'b0, "R1");
        cyc(1'b1, 32'h0000_41AB, 3'b110, 1'b0, 1'b0, "R1");

        // R3: bus mode, reads/writes alike
        wr(2'd2, {28'd0, ARM | BUS});
        cyc(1'b1, 32'h0000_4010, 3'b101, 1'b0, 1'b1, "R3");
        cyc(1'b1, 32'h0000_4000, 3'b001, 1'b0, 1'b1, "R3");
        cyc(1'b1, 32'h0000_4000, 3'b110, 1'b0, 1'b0, "R3");
        cyc(1'b1, 32'h0000_5000, 3'b101, 1'b0, 1'b0, "R1");

        // R4: both enables set
        wr(2'd2, {28'd0, ARM | PROG | BUS});
        cyc(1'b1, 32'h0000_4000, 3'b110, 1'b0, 1'b0, "R4");
        cyc(1'b1, 32'h0000_4000, 3'b101, 1'b0, 1'b0, "R4");

        // R5: single shot self-disarm
        wr(2'd2, {28'd0, ARM | PROG | SGL});
        cyc(1'b1, 32'h0000_4000, 3'b110, 1'b1, 1'b0, "R5");
        cyc(1'b1, 32'h0000_4000, 3'b110, 1'b0, 1'b0, "R5");
        rd_chk(2'd2, {28'd0, PROG | SGL}, "R5");

        // R9: re-arm write coinciding with a single-shot hit
        wr(2'd2, {28'd0, ARM | PROG | SGL});
        op(1'b1, 2'd2, {28'd0, ARM | PROG | SGL}, 1'b1, 32'h0000_4000, 3'b110,
           1'b1, 1'b0, "R9");
        rd_chk(2'd2, {28'd0, ARM | PROG | SGL}, "R9");
        cyc(1'b1, 32'h0000_4000, 3'b110, 1'b1, 1'b0, "R9");
        rd_chk(2'd2, {28'd0, PROG | SGL}, "R5");

        // R7: disarmed bus mode
        wr(2'd2, {28'd0, BUS});
        cyc(1'b1, 32'h0000_4000, 3'b101, 1'b0, 1'b0, "R7");

        repeat (3) cyc(1'b0, '0, 3'b000, 1'b0, 1'b0, "R10");
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule